// File: doc/BRIEF.md
# Display Interrupt Status Unit

This block collects the interrupt conditions of a display controller and drives one level-sensitive interrupt line to the system interrupt controller. Three internal event pulses set bits in a raw status word: DMA finished at end of frame, pixel buffer underrun, and start of vertical sync. A mask word selects which raw bits may reach the line. A masked status word is derived as raw AND mask and can be read back.

Software reaches the block through a simple 32-bit register port that accepts word-sized accesses only. Software can set raw bits directly, which has the same effect as an event. It clears raw bits by writing ones to a separate write-only clear register, and it can read and write the mask. Illegal accesses have no effect and are answered with an error flag. The interrupt line changes state only when the masked status moves between zero and nonzero.

Top module: `irq_stat_unit`

## Requirements
- R1: After reset, raw status and mask are zero, `irq` is low, and `rsp_rdata` and `rsp_err` are zero.
- R2: A one-cycle pulse on `evt_dma_end`, `evt_underrun` or `evt_vsync` sets raw bit 0, 1 or 2 respectively at the next clock edge. Several pulses in one cycle set all their bits.
- R3: A legal write to offset 0x00 (raw status) ORs bits 2:0 of the write data into the raw status. It never clears a bit. A read of 0x00 returns the raw status.
- R4: A legal write to offset 0x04 (clear) clears every raw bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: Offset 0x08 holds the mask. It can be written and read back.
- R6: A read of offset 0x0C returns the raw status ANDed with the mask.
- R7: `irq` rises on the edge where the masked status goes from zero to nonzero and falls on the edge where it returns to zero. At all other times it holds its value, so it is high exactly while the masked status is nonzero.
- R8: When an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R9: An access with `req_bytes` other than 4 sets `rsp_err` and changes no state.
- R10: A read of the clear register, a write to the masked status register, or an access to any offset other than 0x00, 0x04, 0x08 and 0x0C sets `rsp_err` and changes no state.
- R11: Data bits 31:3 read as zero in every register, and writes to them are ignored.
- R12: `rsp_rdata` and `rsp_err` are registered and answer the request of the previous cycle. `rsp_rdata` is zero for writes, for errors and in idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset of the register |
| req_bytes | input | 3 | Access size in bytes; only 4 is legal |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for the previous cycle's request |
| rsp_err | output | 1 | Error flag for the previous cycle's request |
| evt_dma_end | input | 1 | Pulse: DMA idle at end of frame |
| evt_underrun | input | 1 | Pulse: pixel buffer underrun |
| evt_vsync | input | 1 | Pulse: start of vertical sync |
| irq | output | 1 | Level interrupt to the interrupt controller |

## Verification
The status path is driven by event pulses alone, by software set writes alone, and by both mixed, so that the two set sources can each be traced to the read-back word. Mask changes are made while raw bits are already pending. This tells the line reacting to the masked word apart from a line reacting to the raw word or to the edges of events. Clear writes are tried with zero data, with partial data and together with an event on the same bit, which separates write-one-to-clear from plain overwrite and shows which source wins. Wrong sizes, wrong directions and unmapped offsets are each followed by a read, so that an access that was ignored can be told apart from one that was performed and also flagged.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    // Byte offsets of the register window
    localparam int OFS_RAW   = 'h00;
    localparam int OFS_CLEAR = 'h04;
    localparam int OFS_MASK  = 'h08;
    localparam int OFS_STAT  = 'h0C;

    typedef enum logic [1:0] {
        RD_RAW  = 2'd0,
        RD_MASK = 2'd1,
        RD_STAT = 2'd2,
        RD_NONE = 2'd3
    } rd_src_e;

    // Decoded access, one cycle wide
    typedef struct packed {
        logic    set_wr;
        logic    clr_wr;
        logic    mask_wr;
        logic    rd;
        rd_src_e src;
        logic    err;
    } acc_t;

endpackage

// File: rtl/irq_access_decode.sv
module irq_access_decode
    import irq_stat_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int BYTES_W   = 3,
    parameter int ACC_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [BYTES_W-1:0] req_bytes,
    output acc_t               acc
);

    localparam logic [ADDR_W-1:0]  A_RAW   = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0]  A_CLEAR = ADDR_W'(OFS_CLEAR);
    localparam logic [ADDR_W-1:0]  A_MASK  = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0]  A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [BYTES_W-1:0] LEGAL_SZ = BYTES_W'(ACC_BYTES);

    always_comb begin
        acc     = '0;
        acc.src = RD_NONE;
        if (req_valid) begin
            if (req_bytes != LEGAL_SZ) begin
                acc.err = 1'b1;
            end else begin
                unique case (req_addr)
                    A_RAW: begin
                        if (req_write) acc.set_wr = 1'b1;
                        else begin
                            acc.rd  = 1'b1;
                            acc.src = RD_RAW;
                        end
                    end
                    A_CLEAR: begin
                        if (req_write) acc.clr_wr = 1'b1;
                        else           acc.err    = 1'b1;
                    end
                    A_MASK: begin
                        if (req_write) acc.mask_wr = 1'b1;
                        else begin
                            acc.rd  = 1'b1;
                            acc.src = RD_MASK;
                        end
                    end
                    A_STAT: begin
                        if (req_write) acc.err = 1'b1;
                        else begin
                            acc.rd  = 1'b1;
                            acc.src = RD_STAT;
                        end
                    end
                    default: acc.err = 1'b1;
                endcase
            end
        end
    end

    // R9: a wrongly sized access produces an error and no action
    a_r9_size_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_bytes != LEGAL_SZ) |->
        (acc.err && !acc.set_wr && !acc.clr_wr && !acc.mask_wr && !acc.rd));

    // R10: reading the clear register is an error
    a_r10_clear_unreadable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == A_CLEAR) |-> (acc.err && !acc.rd));

    // R10: an error never comes with an action
    a_r10_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        acc.err |-> !(acc.set_wr || acc.clr_wr || acc.mask_wr || acc.rd));

endmodule

// File: rtl/irq_stat_core.sv
module irq_stat_core
    import irq_stat_pkg::*;
#(
    parameter int SRC_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_t             acc,
    input  logic [SRC_N-1:0] wbits,
    input  logic [SRC_N-1:0] evt,
    output logic [SRC_N-1:0] raw,
    output logic [SRC_N-1:0] mask,
    output logic             irq
);

    typedef struct packed {
        logic [SRC_N-1:0] raw;
        logic [SRC_N-1:0] mask;
        logic             irq;
    } st_t;

    st_t              st_d, st_q;
    logic [SRC_N-1:0] set_bits, clr_bits;
    logic [SRC_N-1:0] masked_d, masked_q;

    always_comb begin
        st_d     = st_q;
        set_bits = evt | (acc.set_wr ? wbits : '0);
        clr_bits = acc.clr_wr ? wbits : '0;
        // events and software sets are applied after the clear: they win
        st_d.raw = (st_q.raw & ~clr_bits) | set_bits;
        if (acc.mask_wr) st_d.mask = wbits;
        masked_q = st_q.raw & st_q.mask;
        masked_d = st_d.raw & st_d.mask;
        // the line moves only on a zero / nonzero transition
        if (masked_q == '0 && masked_d != '0)      st_d.irq = 1'b1;
        else if (masked_q != '0 && masked_d == '0) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw  = st_q.raw;
    assign mask = st_q.mask;
    assign irq  = st_q.irq;

    // R7: the line tracks whether the masked status is nonzero
    a_r7_line_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((st_q.raw & st_q.mask) != '0));

    // R8 / R2: every pulsed source is set at the next edge, clear or not
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((st_q.raw & $past(evt)) == $past(evt)));

    // R4: a pure clear leaves the written bits at zero
    a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.clr_wr && evt == '0) |=> ((st_q.raw & $past(wbits)) == '0));

    // R3: a software set never drops a bit that was set
    a_r3_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        acc.set_wr |=> ((st_q.raw & $past(st_q.raw)) == $past(st_q.raw)));

    // R9 / R10: without any action or event the state holds
    a_r10_no_action_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc.set_wr && !acc.clr_wr && !acc.mask_wr && evt == '0) |=> $stable(st_q));

endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
    import irq_stat_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 5,
    parameter int SRC_N     = 3,
    parameter int ACC_BYTES = DATA_W / 8,
    parameter int BYTES_W   = $clog2(ACC_BYTES) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [BYTES_W-1:0] req_bytes,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_err,
    input  logic               evt_dma_end,
    input  logic               evt_underrun,
    input  logic               evt_vsync,
    output logic               irq
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } rsp_t;

    acc_t             acc;
    logic [SRC_N-1:0] evt;
    logic [SRC_N-1:0] raw, mask;
    rsp_t             rsp_d, rsp_q;

    // event encoding: bit 0 DMA end, bit 1 underrun, bit 2 vsync
    always_comb begin
        evt    = '0;
        evt[0] = evt_dma_end;
        evt[1] = evt_underrun;
        evt[2] = evt_vsync;
    end

    irq_access_decode #(
        .ADDR_W   (ADDR_W),
        .BYTES_W  (BYTES_W),
        .ACC_BYTES(ACC_BYTES)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_bytes(req_bytes),
        .acc      (acc)
    );

    irq_stat_core #(
        .SRC_N(SRC_N)
    ) u_core (
        .clk  (clk),
        .rst_n(rst_n),
        .acc  (acc),
        .wbits(req_wdata[SRC_N-1:0]),
        .evt  (evt),
        .raw  (raw),
        .mask (mask),
        .irq  (irq)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.err   = acc.err;
        if (acc.rd) begin
            unique case (acc.src)
                RD_RAW:  rsp_d.rdata = DATA_W'(raw);
                RD_MASK: rsp_d.rdata = DATA_W'(mask);
                RD_STAT: rsp_d.rdata = DATA_W'(raw & mask);
                default: rsp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_rdata = rsp_q.rdata;
    assign rsp_err   = rsp_q.err;

    // R12: an error response carries no data
    a_r12_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));

    // R12: a cycle without request yields an empty response
    a_r12_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (rsp_rdata == '0 && !rsp_err));

    // R11: no bit above the sources ever reads back
    a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_rdata >> SRC_N) == '0);

endmodule

// File: tb/sim_irq_stat_unit.sv
module sim_irq_stat_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [2:0]  req_bytes = 3'd4;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        evt_dma_end = 1'b0;
    logic        evt_underrun = 1'b0;
    logic        evt_vsync = 1'b0;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_stat_unit u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_bytes   (req_bytes),
        .req_wdata   (req_wdata),
        .rsp_rdata   (rsp_rdata),
        .rsp_err     (rsp_err),
        .evt_dma_end (evt_dma_end),
        .evt_underrun(evt_underrun),
        .evt_vsync   (evt_vsync),
        .irq         (irq)
    );

    typedef struct packed {
        logic [3:0]  req;    // requirement number the row targets
        logic        vld;
        logic        wr;
        logic [4:0]  addr;
        logic [2:0]  bytes;
        logic [31:0] wdata;
        logic [2:0]  ev;     // {vsync, underrun, dma_end}
        logic [31:0] x_rdata;
        logic        x_err;
        logic        x_irq;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t TBL [NV] = '{
        '{4'd1,  1, 0, 5'h00, 3'd4, 32'h0,        3'b000, 32'h0, 0, 0}, // R1 read raw
        '{4'd5,  1, 1, 5'h08, 3'd4, 32'h5,        3'b000, 32'h0, 0, 0}, // R5 mask=5
        '{4'd5,  1, 0, 5'h08, 3'd4, 32'h0,        3'b000, 32'h5, 0, 0}, // R5 read mask
        '{4'd2,  0, 0, 5'h00, 3'd4, 32'h0,        3'b001, 32'h0, 0, 1}, // R2 dma end
        '{4'd6,  1, 0, 5'h0C, 3'd4, 32'h0,        3'b000, 32'h1, 0, 1}, // R6 masked
        '{4'd4,  1, 1, 5'h04, 3'd4, 32'h1,        3'b000, 32'h0, 0, 0}, // R4 clear bit0
        '{4'd2,  0, 0, 5'h00, 3'd4, 32'h0,        3'b010, 32'h0, 0, 0}, // R2 underrun, masked off
        '{4'd2,  1, 0, 5'h00, 3'd4, 32'h0,        3'b000, 32'h2, 0, 0}, // R2 read raw
        '{4'd3,  1, 1, 5'h00, 3'd4, 32'h4,        3'b000, 32'h0, 0, 1}, // R3 sw set vsync
        '{4'd4,  1, 1, 5'h04, 3'd4, 32'h0,        3'b000, 32'h0, 0, 1}, // R4 clear zeros
        '{4'd3,  1, 0, 5'h00, 3'd4, 32'h0,        3'b000, 32'h6, 0, 1}, // R3 raw=6
        '{4'd6,  1, 0, 5'h0C, 3'd4, 32'h0,        3'b000, 32'h4, 0, 1}, // R6 masked=4
        '{4'd7,  1, 1, 5'h08, 3'd4, 32'h0,        3'b000, 32'h0, 0, 0}, // R7 mask off drops line
        '{4'd6,  1, 0, 5'h0C, 3'd4, 32'h0,        3'b000, 32'h0, 0, 0}, // R6 masked=0
        '{4'd7,  1, 1, 5'h08, 3'd4, 32'h7,        3'b000, 32'h0, 0, 1}, // R7 mask on raises line
        '{4'd8,  1, 1, 5'h04, 3'd4, 32'h6,        3'b100, 32'h0, 0, 1}, // R8 clear vs vsync
        '{4'd8,  1, 0, 5'h00, 3'd4, 32'h0,        3'b000, 32'h4, 0, 1}, // R8 raw=4
        '{4'd9,  1, 1, 5'h00, 3'd2, 32'h1,        3'b000, 32'h0, 1, 1}, // R9 half-word write
        '{4'd9,  1, 0, 5'h00, 3'd4, 32'h0,        3'b000, 32'h4, 0, 1}, // R9 nothing set
        '{4'd10, 1, 0, 5'h04, 3'd4, 32'h0,        3'b000, 32'h0, 1, 1}, // R10 read clear
        '{4'd10, 1, 1, 5'h0C, 3'd4, 32'h0,        3'b000, 32'h0, 1, 1}, // R10 write status
        '{4'd10, 1, 0, 5'h00, 3'd4, 32'h0,        3'b000, 32'h4, 0, 1}, // R10 raw intact
        '{4'd4,  1, 1, 5'h04, 3'd4, 32'hFFFFFFFF, 3'b000, 32'h0, 0, 0}, // R4 clear all
        '{4'd10, 1, 0, 5'h10, 3'd4, 32'h0,        3'b000, 32'h0, 1, 0}, // R10 unmapped
        '{4'd11, 1, 1, 5'h00, 3'd4, 32'hFFFFFFF8, 3'b000, 32'h0, 0, 0}, // R11 upper bits
        '{4'd11, 1, 0, 5'h00, 3'd4, 32'h0,        3'b000, 32'h0, 0, 0}  // R11 raw still 0
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic v, input logic w, input logic [4:0] a,
                          input logic [2:0] b, input logic [31:0] d, input logic [2:0] e);
        req_valid    = v;
        req_write    = w;
        req_addr     = a;
        req_bytes    = b;
        req_wdata    = d;
        evt_dma_end  = e[0];
        evt_underrun = e[1];
        evt_vsync    = e[2];
        @(posedge clk);
        @(negedge clk);
        req_valid    = 1'b0;
        evt_dma_end  = 1'b0;
        evt_underrun = 1'b0;
        evt_vsync    = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 irq at reset", {31'b0, irq}, 32'h0);
        check("R1 rdata at reset", rsp_rdata, 32'h0);
        check("R1 err at reset", {31'b0, rsp_err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v = TBL[i];
            access(v.vld, v.wr, v.addr, v.bytes, v.wdata, v.ev);
            check($sformatf("R%0d row %0d rdata", v.req, i), rsp_rdata, v.x_rdata);
            check($sformatf("R%0d row %0d err", v.req, i), {31'b0, rsp_err}, {31'b0, v.x_err});
            check($sformatf("R%0d row %0d irq", v.req, i), {31'b0, irq}, {31'b0, v.x_irq});
        end

        // R2: all three sources together, mask zero keeps line low
        access(1, 1, 5'h08, 3'd4, 32'h0, 3'b000);
        access(0, 0, 5'h00, 3'd4, 32'h0, 3'b111);
        check("R2 simultaneous events irq", {31'b0, irq}, 32'h0);
        access(1, 0, 5'h00, 3'd4, 32'h0, 3'b000);
        check("R2 simultaneous events raw", rsp_rdata, 32'h7);

        // R12: idle cycle response is empty
        access(0, 0, 5'h00, 3'd4, 32'h0, 3'b000);
        check("R12 idle rdata", rsp_rdata, 32'h0);

        // R1: reset in the middle of activity
        access(1, 1, 5'h08, 3'd4, 32'h3, 3'b000);
        check("R7 line up before reset", {31'b0, irq}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        access(1, 0, 5'h00, 3'd4, 32'h0, 3'b000);
        check("R1 raw after reset", rsp_rdata, 32'h0);
        access(1, 0, 5'h08, 3'd4, 32'h0, 3'b000);
        check("R1 mask after reset", rsp_rdata, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule